// File: doc/BRIEF.md
# Single-Precision Sign-Injection Unit with Boxing Modes

This unit performs the three single-precision sign-injection operations on 64-bit register operands. The magnitude field (bits 30:0) always comes from the first operand. The sign bit is one of three things: the second operand's sign, its inverse, or the XOR of both signs. A same-source flag marks instructions whose two sources name one register. With that flag set, the three operations act as move, negate and absolute value.

A mode input selects how single-precision values are held in the 64-bit registers. In boxed mode, an operand is valid only when its upper 32 bits are all ones. An operand that fails this check is treated as the canonical quiet NaN. Results are boxed with all-ones upper halves. In integer-register mode, the upper input bits are ignored and results are sign-extended from bit 31. One result leaves the unit per accepted strobe, one clock cycle later.

Top module: `sgnj_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `res_valid` is 0, `res_err` is 0 and `res_data` is all zeros.
- R2: The result of an operation accepted with `op_valid`=1 at a rising edge appears on `res_data`/`res_err` with `res_valid`=1 after that edge. A cycle with `op_valid`=0 gives `res_valid`=0 and leaves `res_data` unchanged.
- R3: Operation code 2'b00 (copy sign) gives bits 30:0 from the first operand and bit 31 from the second operand's bit 31.
- R4: Operation code 2'b01 (negated sign) gives bits 30:0 from the first operand and bit 31 equal to the inverse of the second operand's bit 31.
- R5: Operation code 2'b10 (XOR sign) gives bits 30:0 from the first operand and bit 31 equal to the XOR of both operands' bit 31.
- R6: When `op_same` is 1, `src_b` is ignored and the first operand is used as both sources. Copy sign then moves the value, negated sign flips bit 31, and XOR sign clears bit 31.
- R7: In boxed mode (`int_mode`=0), an operand whose bits 63:32 are not all ones is replaced by 32'h7FC00000 before the operation.
- R8: In boxed mode, every legal-operation result has bits 63:32 all ones above the 32-bit value.
- R9: In integer-register mode (`int_mode`=1), only bits 31:0 of each operand are used, and the result is the 32-bit value sign-extended from bit 31.
- R10: Operation code 2'b11 gives `res_data` all zeros and `res_err`=1 for that result only. A legal operation gives `res_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 copy sign, 01 negated sign, 10 XOR sign, 11 illegal |
| op_same | input | 1 | Both sources name the same register |
| int_mode | input | 1 | 0 boxed storage, 1 integer-register storage |
| src_a | input | 64 | First operand (magnitude source) |
| src_b | input | 64 | Second operand (sign source) |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_data | output | 64 | Formatted 64-bit result |
| res_err | output | 1 | Illegal operation code flag for this result |

## Verification
Each result, together with its valid and error flags, is due exactly one rising edge after the strobe that carried it. No result appears earlier or later. The bench drives each operation on a falling edge and samples the outputs on the next falling edge, half a period after the single register stage has loaded. Idle cycles are sampled the same way, to show that the valid flag drops and the data holds. Back-to-back strobes are also sampled this way, to show that each edge yields its own result.

// File: rtl/sgnj_pkg.sv
package sgnj_pkg;

    parameter int unsigned REG_W = 64;
    parameter int unsigned SP_W  = 32;
    parameter logic [31:0] CANON_QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        OP_COPY = 2'b00,
        OP_NEG  = 2'b01,
        OP_XOR  = 2'b10,
        OP_BAD  = 2'b11
    } sgnj_op_e;

    typedef enum logic {
        FMT_BOXED  = 1'b0,
        FMT_INTREG = 1'b1
    } sgnj_fmt_e;

    // Select the new sign bit from the two incoming signs.
    function automatic logic pick_sign(sgnj_op_e op, logic sa, logic sb);
        logic s;
        case (op)
            OP_COPY: s = sb;
            OP_NEG:  s = ~sb;
            OP_XOR:  s = sa ^ sb;
            default: s = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sgnj_unbox.sv
module sgnj_unbox
    import sgnj_pkg::*;
#(
    parameter int unsigned RW = 64,
    parameter int unsigned SW = 32,
    parameter logic [SW-1:0] QNAN = SW'(32'h7FC0_0000)
) (
    input  logic [RW-1:0] raw,
    input  sgnj_fmt_e     fmt,
    output logic [SW-1:0] value
);
    localparam int unsigned UPPER_W = RW - SW;

    logic box_ok;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign box_ok = &raw[RW-1:SW];
        end else begin : g_flat
            assign box_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        if (fmt == FMT_INTREG) begin
            value = raw[SW-1:0];
        end else if (box_ok) begin
            value = raw[SW-1:0];
        end else begin
            value = QNAN;
        end
    end
endmodule

// File: rtl/sgnj_core.sv
module sgnj_core
    import sgnj_pkg::*;
#(
    parameter int unsigned SW = 32
) (
    input  logic [SW-1:0] opa,
    input  logic [SW-1:0] opb,
    input  sgnj_op_e      op,
    output logic [SW-1:0] value,
    output logic          bad_op
);
    localparam int unsigned SGN = SW - 1;

    always_comb begin
        if (op == OP_BAD) begin
            value  = '0;
            bad_op = 1'b1;
        end else begin
            value  = {pick_sign(op, opa[SGN], opb[SGN]), opa[SGN-1:0]};
            bad_op = 1'b0;
        end
    end
endmodule

// File: rtl/sgnj_box.sv
module sgnj_box
    import sgnj_pkg::*;
#(
    parameter int unsigned RW = 64,
    parameter int unsigned SW = 32
) (
    input  logic [SW-1:0] value,
    input  sgnj_fmt_e     fmt,
    input  logic          zero,
    output logic [RW-1:0] packed_out
);
    localparam int unsigned UPPER_W = RW - SW;

    generate
        if (UPPER_W > 0) begin : g_wide
            logic [UPPER_W-1:0] fill;
            always_comb begin
                if (fmt == FMT_INTREG) begin
                    fill = {UPPER_W{value[SW-1]}};
                end else begin
                    fill = '1;
                end
            end
            assign packed_out = zero ? '0 : {fill, value};
        end else begin : g_same
            assign packed_out = zero ? '0 : value;
        end
    endgenerate
endmodule

// File: rtl/sgnj_unit.sv
module sgnj_unit
    import sgnj_pkg::*;
#(
    parameter int unsigned RW = sgnj_pkg::REG_W,
    parameter int unsigned SW = sgnj_pkg::SP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic          op_same,
    input  logic          int_mode,
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    output logic          res_valid,
    output logic [RW-1:0] res_data,
    output logic          res_err
);
    localparam int unsigned NSRC = 2;
    localparam logic [SW-1:0] QNAN = SW'(CANON_QNAN);

    sgnj_op_e  op_e;
    sgnj_fmt_e fmt_e;
    logic [RW-1:0] raw_src [NSRC];
    logic [SW-1:0] sp_src  [NSRC];
    logic [SW-1:0] core_val;
    logic          core_bad;
    logic [RW-1:0] formatted;

    assign op_e       = sgnj_op_e'(op_code);
    assign fmt_e      = sgnj_fmt_e'(int_mode);
    assign raw_src[0] = src_a;
    assign raw_src[1] = op_same ? src_a : src_b;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            sgnj_unbox #(.RW(RW), .SW(SW), .QNAN(QNAN)) u_unbox (
                .raw   (raw_src[i]),
                .fmt   (fmt_e),
                .value (sp_src[i])
            );
        end
    endgenerate

    sgnj_core #(.SW(SW)) u_core (
        .opa    (sp_src[0]),
        .opb    (sp_src[1]),
        .op     (op_e),
        .value  (core_val),
        .bad_op (core_bad)
    );

    sgnj_box #(.RW(RW), .SW(SW)) u_box (
        .value      (core_val),
        .fmt        (fmt_e),
        .zero       (core_bad),
        .packed_out (formatted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            res_err   <= op_valid & core_bad;
            if (op_valid) begin
                res_data <= formatted;
            end
        end
    end

    // R2: the valid flag follows the strobe by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(res_data)));
    // R3: copy sign in integer mode takes the second sign
    p_copy_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'b00 && !op_same && int_mode)
        |=> res_data[SW-1] == $past(src_b[SW-1]));
    // R8: boxed mode results carry all-ones upper halves
    p_boxed_upper_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !int_mode && op_code != 2'b11)
        |=> &res_data[RW-1:SW]);
    // R9: integer mode results are sign-extended
    p_sext_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && int_mode && op_code != 2'b11)
        |=> res_data[RW-1:SW] == {(RW-SW){res_data[SW-1]}});
    // R10: illegal code zeroes the result and raises the flag
    p_bad_op_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'b11) |=> (res_err && res_data == '0));
    p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (op_code != 2'b11 || !op_valid) |=> !res_err);
endmodule

// File: tb/sgnj_unit_bench.sv
`timescale 1ns/1ps
module sgnj_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_code;
    logic        op_same;
    logic        int_mode;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        res_valid;
    logic [63:0] res_data;
    logic        res_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sgnj_unit u_sgnj_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_same(op_same), .int_mode(int_mode), .src_a(src_a), .src_b(src_b),
        .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation on a falling edge, sample on the next falling edge.
    task automatic run_op(string req, logic [1:0] op, logic same, logic im,
                          logic [63:0] a, logic [63:0] b, logic [63:0] exp,
                          logic exp_err);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_same = same; int_mode = im;
        src_a = a; src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " data"}, res_data, exp);
        chk({req, " valid"}, {63'd0, res_valid}, 64'd1);
        chk({req, " err"}, {63'd0, res_err}, {63'd0, exp_err});
    endtask

    task automatic t_reset();
        rst = 1'b1; op_valid = 1'b0; op_code = 2'b00; op_same = 1'b0;
        int_mode = 1'b0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {63'd0, res_valid}, 64'd0);
        chk("R1 data in reset", res_data, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {63'd0, res_valid}, 64'd0);
        chk("R1 err after reset", {63'd0, res_err}, 64'd0);
        chk("R1 data after reset", res_data, 64'd0);
    endtask

    task automatic t_boxed_ops();
        run_op("R3 R8 copy", 2'b00, 0, 0, 64'hFFFFFFFF_3F800000,
               64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_BF800000, 0);
        run_op("R4 R8 negate", 2'b01, 0, 0, 64'hFFFFFFFF_40490FDB,
               64'hFFFFFFFF_00000000, 64'hFFFFFFFF_C0490FDB, 0);
        run_op("R5 R8 xor", 2'b10, 0, 0, 64'hFFFFFFFF_C0000000,
               64'hFFFFFFFF_80000000, 64'hFFFFFFFF_40000000, 0);
    endtask

    task automatic t_same_src();
        run_op("R6 move", 2'b00, 1, 0, 64'hFFFFFFFF_BF800000,
               64'hFFFFFFFF_00000000, 64'hFFFFFFFF_BF800000, 0);
        run_op("R6 negate", 2'b01, 1, 0, 64'hFFFFFFFF_3F800000,
               64'hFFFFFFFF_80000000, 64'hFFFFFFFF_BF800000, 0);
        run_op("R6 abs", 2'b10, 1, 0, 64'hFFFFFFFF_BF800000,
               64'hFFFFFFFF_80000000, 64'hFFFFFFFF_3F800000, 0);
    endtask

    task automatic t_bad_box();
        run_op("R7 bad a", 2'b00, 0, 0, 64'h00000000_3F800000,
               64'hFFFFFFFF_00000000, 64'hFFFFFFFF_7FC00000, 0);
        run_op("R7 bad b", 2'b00, 0, 0, 64'hFFFFFFFF_3F800000,
               64'h12345678_FFFFFFFF, 64'hFFFFFFFF_3F800000, 0);
    endtask

    task automatic t_int_mode();
        run_op("R9 copy", 2'b00, 0, 1, 64'hDEADBEEF_3F800000,
               64'h00000000_80000000, 64'hFFFFFFFF_BF800000, 0);
        run_op("R9 xor", 2'b10, 0, 1, 64'h12345678_C0000000,
               64'h00000000_00000000, 64'hFFFFFFFF_C0000000, 0);
        run_op("R9 negate", 2'b01, 0, 1, 64'h00000000_BF800000,
               64'hFFFFFFFF_FFFFFFFF, 64'h00000000_3F800000, 0);
    endtask

    task automatic t_illegal();
        run_op("R10 illegal", 2'b11, 0, 0, 64'hFFFFFFFF_3F800000,
               64'hFFFFFFFF_80000000, 64'h0, 1);
        run_op("R10 err clears", 2'b00, 0, 0, 64'hFFFFFFFF_3F800000,
               64'hFFFFFFFF_80000000, 64'hFFFFFFFF_BF800000, 0);
    endtask

    task automatic t_idle_and_stream();
        // idle cycle: valid drops, data holds previous result
        @(negedge clk);
        src_a = 64'hFFFFFFFF_11111111; op_code = 2'b01;
        @(negedge clk);
        chk("R2 idle valid", {63'd0, res_valid}, 64'd0);
        chk("R2 idle hold", res_data, 64'hFFFFFFFF_BF800000);
        // back-to-back strobes
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b00; op_same = 1'b0; int_mode = 1'b0;
        src_a = 64'hFFFFFFFF_00000001; src_b = 64'hFFFFFFFF_80000000;
        @(negedge clk);
        chk("R2 stream first", res_data, 64'hFFFFFFFF_80000001);
        op_code = 2'b10; src_a = 64'hFFFFFFFF_80000002;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 stream second", res_data, 64'hFFFFFFFF_00000002);
        chk("R2 stream valid", {63'd0, res_valid}, 64'd1);
        @(negedge clk);
        chk("R2 stream end", {63'd0, res_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_boxed_ops();
        t_same_src();
        t_bad_box();
        t_int_mode();
        t_illegal();
        t_idle_and_stream();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule